// File: doc/BRIEF.md
# Polarity-Aware Hysteresis Current Controller

This block closes the inner current loop of a bridgeless single-phase rectifier with a bang-bang law. Each system clock it takes a signed sample of the inductor current and a signed current reference, and forms their difference as a tracking error. It compares that error against a programmable half-band and drives a one-bit switch command. The command is set or cleared when the error leaves the band and is held while the error stays inside it, in the way a set-reset latch behaves. The ripple of the tracked current is therefore fixed at twice the half-band, and the switching frequency floats.

Which band edge turns the switches on depends on the half-cycle of the AC input. A polarity input, registered inside the block, swaps the meaning of the two band crossings. One controller therefore serves both half-cycles of the line. An enable input holds the command off, for example during start-up or a fault.

Top module: `hyst_iloop_ctrl`

## Requirements
- R1: The tracking error is `i_meas - i_ref` computed on 17 signed bits, so the extremes never wrap: `i_meas=32767, i_ref=-32768` is a large positive error and `i_meas=-32768, i_ref=32767` a large negative one.
- R2: With registered polarity positive (`pol_neg` sampled as 0), an error strictly greater than +h clears `sw_on` on the next rising clock edge.
- R3: With registered polarity positive, an error strictly less than -h sets `sw_on` on the next rising clock edge.
- R4: With registered polarity negative (`pol_neg` sampled as 1), an error strictly less than -h clears `sw_on`, and an error strictly greater than +h sets it, on the next rising edge.
- R5: While -h <= error <= +h, including the two band edges, `sw_on` keeps its value.
- R6: `pol_neg` is captured in a register on each rising edge, and the mapping applied at an edge is the one captured on the previous edge. A polarity change alone never forces `sw_on` to a value.
- R7: While `en` is 0, `sw_on` is 0 after the next rising edge. After `en` returns to 1 with the error inside the band, `sw_on` stays 0.
- R8: Asynchronous active-low reset drives `sw_on` to 0 and the registered polarity to positive.
- R9: The half-band h is taken from `half_band` as a signed value, and a negative setting is treated as h = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | 1 lets the hysteresis law run, 0 forces the switch command off |
| pol_neg | input | 1 | AC input polarity: 0 positive half-cycle, 1 negative |
| i_meas | input | 16 | Signed sampled inductor current |
| i_ref | input | 16 | Signed current reference |
| half_band | input | 16 | Signed half-band h of the hysteresis window |
| sw_on | output | 1 | Switch command: 1 switches on, 0 off |

## Verification
The bench places the error exactly on +h and -h, where a design with inclusive comparisons would toggle instead of holding. It drives full-scale opposite-sign current and reference, where a 16-bit subtraction wraps to a small value and leaves the command stuck. It flips the polarity in the same cycle as an out-of-band error, which catches a design that applies the new mapping too early or forces the command at the change. A negative half-band shows up as a design that clears the switch on a zero error. Dropping the enable and re-enabling inside the band catches a command that resumes its old value.

// File: rtl/hic_pkg.sv
package hic_pkg;
   // Encoding of the registered AC polarity.
   typedef enum logic {
      POL_POS = 1'b0,
      POL_NEG = 1'b1
   } pol_e;

   // Action requested by the band comparators for one clock.
   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_SET  = 2'b01,
      ACT_CLR  = 2'b10
   } act_e;
endpackage

// File: rtl/hic_err_sub.sv
module hic_err_sub #(
   parameter int W = 16
) (
   input  logic signed [W-1:0] meas,
   input  logic signed [W-1:0] refv,
   output logic signed [W:0]   err
);
   localparam int EW = W + 1;

   logic signed [EW-1:0] meas_x;
   logic signed [EW-1:0] ref_x;

   // Sign-extend one bit so the difference of two full-scale samples fits.
   always_comb begin
      meas_x = {meas[W-1], meas};
      ref_x  = {refv[W-1], refv};
      err    = meas_x - ref_x;
   end
endmodule

// File: rtl/hic_band_cmp.sv
module hic_band_cmp #(
   parameter int W           = 16,
   parameter bit SIGNED_BAND = 1'b1
) (
   input  logic signed [W:0]   err,
   input  logic        [W-1:0] band,
   output logic                above,
   output logic                below
);
   localparam int EW = W + 1;

   logic signed [EW-1:0] h_pos;
   logic signed [EW-1:0] h_neg;

   generate
      if (SIGNED_BAND) begin : g_signed_band
         // Negative half-band collapses to zero width.
         always_comb begin
            if (band[W-1]) h_pos = '0;
            else           h_pos = {1'b0, band};
         end
      end else begin : g_unsigned_band
         always_comb h_pos = {1'b0, band};
      end
   endgenerate

   always_comb begin
      h_neg = -h_pos;
      above = (err > h_pos);
      below = (err < h_neg);
   end
endmodule

// File: rtl/hic_sw_state.sv
module hic_sw_state
   import hic_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pol_in,
   input  logic above,
   input  logic below,
   output logic pol_q,
   output logic u
);
   pol_e pol_r;
   act_e act;
   logic u_next;

   // Polarity picks which band edge sets and which clears the command.
   always_comb begin
      act = ACT_HOLD;
      if (pol_r == POL_POS) begin
         if (above)      act = ACT_CLR;
         else if (below) act = ACT_SET;
      end else begin
         if (below)      act = ACT_CLR;
         else if (above) act = ACT_SET;
      end
   end

   always_comb begin
      unique case (act)
         ACT_SET: u_next = 1'b1;
         ACT_CLR: u_next = 1'b0;
         default: u_next = u;
      endcase
      if (!en) u_next = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         u     <= 1'b0;
         pol_r <= POL_POS;
      end else begin
         u     <= u_next;
         pol_r <= pol_e'(pol_in);
      end
   end

   assign pol_q = pol_r;
endmodule

// File: rtl/hyst_iloop_ctrl.sv
module hyst_iloop_ctrl #(
   parameter int W           = 16,
   parameter bit SIGNED_BAND = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         pol_neg,
   input  logic [W-1:0] i_meas,
   input  logic [W-1:0] i_ref,
   input  logic [W-1:0] half_band,
   output logic         sw_on
);
   localparam int EW = W + 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("hyst_iloop_ctrl: W must be at least 2");
      end
   endgenerate

   logic signed [EW-1:0] err;
   logic                 above;
   logic                 below;
   logic                 pol_q;

   hic_err_sub #(.W(W)) u_err (
      .meas (i_meas),
      .refv (i_ref),
      .err  (err)
   );

   hic_band_cmp #(.W(W), .SIGNED_BAND(SIGNED_BAND)) u_cmp (
      .err   (err),
      .band  (half_band),
      .above (above),
      .below (below)
   );

   hic_sw_state u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .pol_in (pol_neg),
      .above  (above),
      .below  (below),
      .pol_q  (pol_q),
      .u      (sw_on)
   );
endmodule

// File: rtl/hic_chk.sv
module hic_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic pol_q,
   input logic above,
   input logic below,
   input logic u
);
   // R8
   rst_state_chk: assert property (@(posedge clk) !rst_n |-> (!u && !pol_q));

   // R7
   en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !u);

   // R2
   pos_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !pol_q && above) |=> !u);

   // R3
   pos_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !pol_q && below) |=> u);

   // R4
   neg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pol_q && below) |=> !u);

   // R4
   neg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pol_q && above) |=> u);

   // R5
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !above && !below) |=> $stable(u));

   // R9
   band_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(above && below));
endmodule

bind hyst_iloop_ctrl hic_chk u_hic_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (en),
   .pol_q (pol_q),
   .above (above),
   .below (below),
   .u     (sw_on)
);

// File: tb/hyst_iloop_ctrl_bench.sv
module hyst_iloop_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        pol_neg = 1'b0;
   logic [15:0] i_meas = '0;
   logic [15:0] i_ref = '0;
   logic [15:0] half_band = '0;
   logic        sw_on;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic  exp;
      string tag;
   } item_t;
   item_t sb[$];

   // Reference model state
   logic m_u = 1'b0;
   logic m_pol = 1'b0;

   always #5 clk = ~clk;

   hyst_iloop_ctrl u_hyst_iloop_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .pol_neg   (pol_neg),
      .i_meas    (i_meas),
      .i_ref     (i_ref),
      .half_band (half_band),
      .sw_on     (sw_on)
   );

   function automatic logic model_next(logic cur, logic e_n, logic pq,
                                       int err, int h_raw);
      int h;
      h = (h_raw < 0) ? 0 : h_raw;
      if (!e_n) return 1'b0;
      if (!pq) begin
         if (err > h)  return 1'b0;
         if (err < -h) return 1'b1;
      end else begin
         if (err < -h) return 1'b0;
         if (err > h)  return 1'b1;
      end
      return cur;
   endfunction

   task automatic step(input logic e_n, input logic p, input int meas,
                       input int rf, input int h, input string tag);
      item_t it;
      @(negedge clk);
      en        = e_n;
      pol_neg   = p;
      i_meas    = 16'(meas);
      i_ref     = 16'(rf);
      half_band = 16'(h);
      m_u   = model_next(m_u, e_n, m_pol, meas - rf, h);
      m_pol = p;
      it.exp = m_u;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // Monitor: compares each result shortly after the edge that produced it.
   always @(posedge clk) begin
      #2;
      if (rst_n && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (sw_on !== it.exp) begin
            errors++;
            $display("FAIL %s: sw_on=%0b expected %0b", it.tag, sw_on, it.exp);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (sw_on !== 1'b0) begin
         errors++;
         $display("FAIL R8 reset: sw_on=%0b expected 0", sw_on);
      end
      rst_n = 1'b1;
      @(negedge clk);

      step(1, 0,      0,      0,  100, "R5 zero error holds 0");
      step(1, 0,   -101,      0,  100, "R3 below -h sets");
      step(1, 0,    100,      0,  100, "R5 error at +h holds 1");
      step(1, 0,    101,      0,  100, "R2 above +h clears");
      step(1, 0,   -100,      0,  100, "R5 error at -h holds 0");
      step(1, 1,   -200,      0,  100, "R6 old polarity still applied");
      step(1, 1,      0,      0,  100, "R6 polarity change alone holds");
      step(1, 1,   -200,      0,  100, "R4 negative below -h clears");
      step(1, 1,    300,      0,  100, "R4 negative above +h sets");
      step(1, 1,   1000,    900,  100, "R5 band edge in negative holds");
      step(0, 1,    300,      0,  100, "R7 enable low forces 0");
      step(1, 1,      0,      0,  100, "R7 re-enable inside band stays 0");
      step(1, 0,   -500,      0,  100, "R6 negative mapping on last edge");
      step(1, 0,   -500,      0,  100, "R3 positive below -h sets");
      step(1, 0,  32767, -32768,  100, "R1 full-scale positive clears");
      step(1, 0, -32768,  32767,  100, "R1 full-scale negative sets");
      step(1, 0,   1234,   1234,  -50, "R9 negative band zero error holds");
      step(1, 0,   1235,   1234,  -50, "R9 negative band +1 clears");
      step(1, 0,   1233,   1234,  -50, "R9 negative band -1 sets");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule